// File: doc/BRIEF.md
# Timed Sleep-Mode Power Controller

This block decides when the data-link layer of an optical network unit may power down. It watches the frames that arrive. When a valid frame carries a sleep-request flag in its header, the controller leaves full operation. It then walks through three timed phases: a power-down transition, a low-power idle period, and a power-up transition. After the last phase it returns to full operation. Each phase lasts a fixed number of clock cycles, set by a parameter. At a 125 MHz clock the defaults give 2.88 µs, 39.68 µs and 4.48 µs, which is 47.04 µs for the whole excursion.

The outputs drive the rest of the unit. A one-hot state word reports the current phase. A transceiver power enable drops only during the idle period. A ready flag tells the datapath when it may accept traffic. Four saturating counters add up the cycles spent in each state, so software can compute the energy saved from the time spent in each phase.

Top module: `pwr_sleep_ctl`

## Requirements
- R1: `state_onehot` always has exactly one bit set. Bit 0 is Active, bit 1 is Sleep, bit 2 is Low-Power-Idle and bit 3 is Wake. After reset it reads 4'b0001.
- R2: In Active, a cycle with `frame_vld` and `hdr_sleep_req` both high moves the state to Sleep on the next cycle. `hdr_sleep_req` without `frame_vld` has no effect.
- R3: Once started, the phases always run in the order Sleep, Low-Power-Idle, Wake, Active.
- R4: Sleep lasts exactly `SLEEP_CYC` cycles, Low-Power-Idle exactly `IDLE_CYC` cycles and Wake exactly `WAKE_CYC` cycles. `SLEEP_CYC` and `WAKE_CYC` are at least 1.
- R5: With `IDLE_CYC` = 0, Sleep is followed directly by Wake, and Low-Power-Idle is never entered.
- R6: `xcvr_pwr_en` is low in Low-Power-Idle and high in every other state.
- R7: `dp_ready` is high in Active and low in Sleep, Low-Power-Idle and Wake.
- R8: A sleep request seen outside Active is dropped. It is not stored, it does not restart the sequence, and it does not cause a new excursion after the return to Active.
- R9: In every cycle without reset, the counter of the state held during that cycle rises by one. It saturates at all ones.
- R10: `stat_clr` zeroes all four counters at the next edge. This takes priority over counting and over reset.
- R11: `rst` forces Active at the next edge and abandons any phase timing in progress. The counters hold their values during reset unless `stat_clr` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | Strobe marking a received frame header |
| hdr_sleep_req | input | 1 | Sleep-request flag from that header |
| stat_clr | input | 1 | Clears all residency counters |
| state_onehot | output | 4 | Current state, one-hot (see R1) |
| xcvr_pwr_en | output | 1 | Transceiver power enable |
| dp_ready | output | 1 | Datapath may accept traffic |
| cnt_active | output | STAT_W | Cycles spent in Active |
| cnt_sleep | output | STAT_W | Cycles spent in Sleep |
| cnt_lpi | output | STAT_W | Cycles spent in Low-Power-Idle |
| cnt_wake | output | STAT_W | Cycles spent in Wake |

## Verification
The hardest situations to reach from the ports are saturation of the Sleep counter and the `IDLE_CYC` = 0 variant. Saturation needs dozens of complete excursions before the counter reaches its limit. To keep the run short, the bench narrows the counters to 8 bits and fires more than fifty back-to-back requests. The bench also runs a second instance with no idle period on the same stimulus. A reset that lands in the middle of the idle period checks that the phase timing is abandoned while the counters keep their values.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_SLEEP  = 2'd1,
        PS_IDLE   = 2'd2,
        PS_WAKE   = 2'd3
    } pwr_state_e;

    localparam int NUM_STATES = 4;

    function automatic logic [NUM_STATES-1:0] to_onehot(input pwr_state_e s);
        logic [NUM_STATES-1:0] r;
        r    = '0;
        r[s] = 1'b1;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwr_sat_ctr.sv
module pwr_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (inc && (q != {W{1'b1}}))
            q <= q + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_ctl_pkg::*;
#(
    parameter int SLEEP_CYC = 360,
    parameter int IDLE_CYC  = 4960,
    parameter int WAKE_CYC  = 560
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    output pwr_state_e state
);
    localparam int MAX_DW  = max3(SLEEP_CYC, IDLE_CYC, WAKE_CYC);
    localparam int DW_W    = $clog2(MAX_DW + 1);
    localparam int SL_LAST = SLEEP_CYC - 1;
    localparam int ID_LAST = (IDLE_CYC > 0) ? IDLE_CYC - 1 : 0;
    localparam int WK_LAST = WAKE_CYC - 1;

    logic [DW_W-1:0] dwell, dwell_nxt;
    pwr_state_e      state_nxt, after_sleep;

    generate
        if (IDLE_CYC == 0) begin : g_no_idle
            assign after_sleep = PS_WAKE;
        end else begin : g_idle
            assign after_sleep = PS_IDLE;
        end
    endgenerate

    always_comb begin
        state_nxt = state;
        dwell_nxt = dwell + 1'b1;
        unique case (state)
            PS_ACTIVE: begin
                dwell_nxt = '0;
                if (trig) state_nxt = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (dwell == DW_W'(SL_LAST)) begin
                    state_nxt = after_sleep;
                    dwell_nxt = '0;
                end
            end
            PS_IDLE: begin
                if (dwell == DW_W'(ID_LAST)) begin
                    state_nxt = PS_WAKE;
                    dwell_nxt = '0;
                end
            end
            PS_WAKE: begin
                if (dwell == DW_W'(WK_LAST)) begin
                    state_nxt = PS_ACTIVE;
                    dwell_nxt = '0;
                end
            end
            default: begin
                state_nxt = PS_ACTIVE;
                dwell_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_ACTIVE;
            dwell <= '0;
        end else begin
            state <= state_nxt;
            dwell <= dwell_nxt;
        end
    end
endmodule

// File: rtl/pwr_stat_bank.sv
module pwr_stat_bank
    import pwr_ctl_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic                              clk,
    input  logic                              hold,
    input  logic                              clr,
    input  logic [NUM_STATES-1:0]             in_state,
    output logic [NUM_STATES-1:0][STAT_W-1:0] counts
);
    generate
        for (genvar i = 0; i < NUM_STATES; i++) begin : g_ctr
            pwr_sat_ctr #(.W(STAT_W)) ctr_i (
                .clk (clk),
                .clr (clr),
                .inc (in_state[i] & ~hold),
                .q   (counts[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pwr_sleep_ctl.sv
module pwr_sleep_ctl
    import pwr_ctl_pkg::*;
#(
    parameter int SLEEP_CYC = 360,
    parameter int IDLE_CYC  = 4960,
    parameter int WAKE_CYC  = 560,
    parameter int STAT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic              hdr_sleep_req,
    input  logic              stat_clr,
    output logic [3:0]        state_onehot,
    output logic              xcvr_pwr_en,
    output logic              dp_ready,
    output logic [STAT_W-1:0] cnt_active,
    output logic [STAT_W-1:0] cnt_sleep,
    output logic [STAT_W-1:0] cnt_lpi,
    output logic [STAT_W-1:0] cnt_wake
);
    pwr_state_e                        cur_state;
    logic [NUM_STATES-1:0]             oh;
    logic [NUM_STATES-1:0][STAT_W-1:0] counts;

    pwr_seq_fsm #(
        .SLEEP_CYC (SLEEP_CYC),
        .IDLE_CYC  (IDLE_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .trig  (frame_vld & hdr_sleep_req),
        .state (cur_state)
    );

    assign oh = to_onehot(cur_state);

    pwr_stat_bank #(.STAT_W(STAT_W)) stats_i (
        .clk      (clk),
        .hold     (rst),
        .clr      (stat_clr),
        .in_state (oh),
        .counts   (counts)
    );

    assign state_onehot = oh;
    assign xcvr_pwr_en  = (cur_state != PS_IDLE);
    assign dp_ready     = (cur_state == PS_ACTIVE);
    assign cnt_active   = counts[PS_ACTIVE];
    assign cnt_sleep    = counts[PS_SLEEP];
    assign cnt_lpi      = counts[PS_IDLE];
    assign cnt_wake     = counts[PS_WAKE];
endmodule

// File: rtl/pwr_sleep_ctl_chk.sv
module pwr_sleep_ctl_chk #(
    parameter int IDLE_CYC = 4960,
    parameter int STAT_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic              hdr_sleep_req,
    input logic              stat_clr,
    input logic [3:0]        state_onehot,
    input logic              xcvr_pwr_en,
    input logic              dp_ready,
    input logic [STAT_W-1:0] cnt_active,
    input logic [STAT_W-1:0] cnt_sleep,
    input logic [STAT_W-1:0] cnt_lpi,
    input logic [STAT_W-1:0] cnt_wake
);
    // R1
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_onehot) == 1);

    // R2
    trigger_chk: assert property (@(posedge clk) disable iff (rst)
        state_onehot[0] && frame_vld && hdr_sleep_req |=> state_onehot[1]);

    // R3
    idle_order_chk: assert property (@(posedge clk) disable iff (rst)
        state_onehot[2] |=> state_onehot[2] || state_onehot[3]);

    // R3
    wake_order_chk: assert property (@(posedge clk) disable iff (rst)
        state_onehot[3] |=> state_onehot[3] || state_onehot[0]);

    // R7
    ready_power_chk: assert property (@(posedge clk) disable iff (rst)
        dp_ready |-> xcvr_pwr_en);

    // R8
    stay_active_chk: assert property (@(posedge clk) disable iff (rst)
        state_onehot[0] && !(frame_vld && hdr_sleep_req) |=> state_onehot[0]);

    // R9
    active_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> cnt_active >= $past(cnt_active));

    // R10
    clear_chk: assert property (@(posedge clk)
        stat_clr |=> (cnt_active == '0) && (cnt_sleep == '0) && (cnt_wake == '0));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> state_onehot[0]);

    generate
        if (IDLE_CYC == 0) begin : g_skip
            // R5
            no_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !stat_clr |=> cnt_lpi == $past(cnt_lpi));
        end
    endgenerate
endmodule

bind pwr_sleep_ctl pwr_sleep_ctl_chk #(
    .IDLE_CYC (IDLE_CYC),
    .STAT_W   (STAT_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .frame_vld     (frame_vld),
    .hdr_sleep_req (hdr_sleep_req),
    .stat_clr      (stat_clr),
    .state_onehot  (state_onehot),
    .xcvr_pwr_en   (xcvr_pwr_en),
    .dp_ready      (dp_ready),
    .cnt_active    (cnt_active),
    .cnt_sleep     (cnt_sleep),
    .cnt_lpi       (cnt_lpi),
    .cnt_wake      (cnt_wake)
);

// File: tb/pwr_sleep_ctl_tb_top.sv
module pwr_sleep_ctl_tb_top;
    localparam int SL = 5;
    localparam int ID = 8;
    localparam int WK = 4;
    localparam int SW = 8;
    localparam int SAT = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1, frame_vld = 1'b0, hdr_sleep_req = 1'b0, stat_clr = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]    st   [2];
    logic          pwr  [2];
    logic          rdy  [2];
    logic [SW-1:0] cnt  [2][4];

    pwr_sleep_ctl #(.SLEEP_CYC(SL), .IDLE_CYC(ID), .WAKE_CYC(WK), .STAT_W(SW)) dut_i (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .hdr_sleep_req(hdr_sleep_req),
        .stat_clr(stat_clr), .state_onehot(st[0]), .xcvr_pwr_en(pwr[0]), .dp_ready(rdy[0]),
        .cnt_active(cnt[0][0]), .cnt_sleep(cnt[0][1]), .cnt_lpi(cnt[0][2]), .cnt_wake(cnt[0][3]));

    pwr_sleep_ctl #(.SLEEP_CYC(SL), .IDLE_CYC(0), .WAKE_CYC(WK), .STAT_W(SW)) dut_z (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .hdr_sleep_req(hdr_sleep_req),
        .stat_clr(stat_clr), .state_onehot(st[1]), .xcvr_pwr_en(pwr[1]), .dp_ready(rdy[1]),
        .cnt_active(cnt[1][0]), .cnt_sleep(cnt[1][1]), .cnt_lpi(cnt[1][2]), .cnt_wake(cnt[1][3]));

    int checks = 0, errors = 0;
    bit chk_en = 1'b0;
    int m_st   [2];
    int m_left [2];
    int m_cnt  [2][4];
    int idle_len [2] = '{ID, 0};

    // reference model: remaining-cycle countdown per phase
    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (stat_clr) begin
                for (int k = 0; k < 4; k++) m_cnt[u][k] = 0;
            end else if (!rst && m_cnt[u][m_st[u]] < SAT) begin
                m_cnt[u][m_st[u]] = m_cnt[u][m_st[u]] + 1;
            end
            if (rst) begin
                m_st[u] = 0;
                m_left[u] = 0;
            end else if (m_st[u] == 0) begin
                if (frame_vld && hdr_sleep_req) begin
                    m_st[u] = 1;
                    m_left[u] = SL;
                end
            end else begin
                m_left[u] = m_left[u] - 1;
                if (m_left[u] == 0) begin
                    if (m_st[u] == 1 && idle_len[u] > 0) begin
                        m_st[u] = 2; m_left[u] = idle_len[u];
                    end else if (m_st[u] == 3) begin
                        m_st[u] = 0;
                    end else begin
                        m_st[u] = 3; m_left[u] = WK;
                    end
                end
            end
        end
        chk_en = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_en) begin
        for (int u = 0; u < 2; u++) begin
            check(st[u] == (4'b1 << m_st[u]), "R1 R2 R3 R4 R5 R8 R11 state",
                  int'(st[u]), int'(4'b1 << m_st[u]));
            check(pwr[u] == (m_st[u] != 2), "R6 power enable", int'(pwr[u]), int'(m_st[u] != 2));
            check(rdy[u] == (m_st[u] == 0), "R7 ready", int'(rdy[u]), int'(m_st[u] == 0));
            for (int k = 0; k < 4; k++)
                check(int'(cnt[u][k]) == m_cnt[u][k], "R9 R10 R11 counter",
                      int'(cnt[u][k]), m_cnt[u][k]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req_pulse();
        @(negedge clk); frame_vld = 1'b1; hdr_sleep_req = 1'b1;
        @(negedge clk); frame_vld = 1'b0; hdr_sleep_req = 1'b0;
    endtask

    initial begin
        cyc(2); stat_clr = 1'b0;            // R10 clear during reset
        cyc(1); rst = 1'b0;
        cyc(5);
        hdr_sleep_req = 1'b1; cyc(3); hdr_sleep_req = 1'b0;   // R2 flag alone
        frame_vld = 1'b1; cyc(2); frame_vld = 1'b0;
        req_pulse();                          // R3 R4 full excursion
        cyc(9);
        frame_vld = 1'b1; hdr_sleep_req = 1'b1; cyc(1);  // R8 during idle
        frame_vld = 1'b0; hdr_sleep_req = 1'b0;
        cyc(20);
        frame_vld = 1'b1; hdr_sleep_req = 1'b1; cyc(60); // held request
        frame_vld = 1'b0; hdr_sleep_req = 1'b0; cyc(20);
        req_pulse(); cyc(8);                  // R11 reset inside idle
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(10);
        req_pulse(); cyc(3);                  // R10 clear mid-sequence
        stat_clr = 1'b1; cyc(1); stat_clr = 1'b0; cyc(20);
        for (int i = 0; i < 60; i++) begin    // R9 saturate sleep counter
            req_pulse(); cyc(18);
        end
        cyc(300);                             // R9 saturate active counter
        rst = 1'b1; stat_clr = 1'b1; cyc(1);  // R10 over reset
        stat_clr = 1'b0; rst = 1'b0; cyc(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule